// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block sits in the feedback path of a frequency synthesizer. It divides a fast input clock, which stands in for the oscillator or prescaler domain, by a total ratio of P×N+A. A dual-modulus prescaler, modelled digitally, counts either P or P+1 input cycles per output tick. A swallow counter holds the prescaler at P+1 for the first A ticks of each output period. A main counter ends the period after N ticks in total. At that point the block raises a one-cycle pulse for a phase comparator.

The base modulus P is chosen by two configuration bits. The high band offers 64 or 128, and the low band offers 8 or 16. The swallow value A (7 bits), the main value N (11 bits) and the modulus choice are sampled only when a period ends, or while reset is held. Software can therefore rewrite them at any time without breaking a period in progress. A main value below 3 is raised to 3.

Top module: `swallow_divider`

## Requirements
- R1: While `rst` is high, `divPulse` is 0. After `rst` falls, the first `divPulse` appears in the sample that follows the R-th rising edge after release, where R = P×N+A for the configuration held during reset.
- R2: With `bandSel`=1 and `ratioSel`=0 (P=8), the distance between consecutive `divPulse` samples is 8×N+A input cycles.
- R3: With `bandSel`=1 and `ratioSel`=1 (P=16), the distance between pulses is 16×N+A cycles.
- R4: With `bandSel`=0, P is 64 when `ratioSel`=0 and 128 when `ratioSel`=1, and the distance between pulses is P×N+A.
- R5: Within each period, `modCtl` is high for exactly (P+1)×A cycles, starting at the pulse cycle, and is then low until the next pulse. `modCtl` never rises except in a cycle where `divPulse` is high.
- R6: `divPulse` is high for exactly one cycle per period.
- R7: With A=0, `modCtl` stays low for the whole period and the ratio is P×N.
- R8: With A=N, `modCtl` stays high for the whole period and the ratio is (P+1)×N.
- R9: A main value of 0, 1 or 2 behaves exactly as N=3.
- R10: Changes to `swallowVal`, `mainVal`, `bandSel` or `ratioSel` made during a period leave that period's length unchanged. They apply from the next period onwards.
- R11: The largest main value, N=2047, with A=127 gives a ratio of P×2047+127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast divider input clock |
| rst | input | 1 | Synchronous reset, active high; loads the configuration |
| bandSel | input | 1 | 0: high band (P = 64 or 128); 1: low band (P = 8 or 16) |
| ratioSel | input | 1 | 0: smaller modulus of the band; 1: larger |
| swallowVal | input | 7 | Swallow count A, 0 to 127 |
| mainVal | input | 11 | Main count N, 3 to 2047 (lower values treated as 3) |
| modCtl | output | 1 | High while the prescaler divides by P+1 |
| divPulse | output | 1 | One-cycle pulse marking the end of each period |

## Verification
The assertions assume that the swallow value never exceeds the effective main value. If it did, the swallow phase could not finish before the main count ends. The minimum-ratio check also relies on P being at least 8.

Every stimulus vector and directed case keeps A ≤ max(N,3). Configuration inputs change only at falling clock edges, away from the rising edge where they are sampled. Only the periods that follow a reload are measured, so each measured period has a settled configuration.

// File: rtl/swallow_divider_pkg.sv
package swallow_divider_pkg;

  typedef enum logic {
    BAND_HIGH = 1'b0,
    BAND_LOW  = 1'b1
  } bandSel_e;

  // strobes from the control to the datapath; exactly one is set per cycle
  typedef struct packed {
    logic load;   // start of a new period: latch configuration, reload all counters
    logic step;   // prescaler tick inside a period: advance swallow and main counters
    logic count;  // ordinary input cycle: prescaler counts down
  } divStrobe_t;

endpackage

// File: rtl/swallow_divider_prescaler.sv
module swallow_divider_prescaler
  import swallow_divider_pkg::*;
#(
  parameter int P_HI_LO = 64,
  parameter int P_HI_HI = 128,
  parameter int P_LO_LO = 8,
  parameter int P_LO_HI = 16,
  localparam int PRE_W = $clog2(P_HI_HI + 1)
) (
  input  logic       clk,
  input  divStrobe_t strobe,
  input  logic       bandSel,
  input  logic       ratioSel,
  input  logic       loadWide,   // first tick of the new period uses P+1
  input  logic       nextWide,   // next tick uses P+1
  output logic       preZero
);

  logic [PRE_W-1:0] newP;
  logic [PRE_W-1:0] curP;
  logic [PRE_W-1:0] preCnt;

  // base modulus chosen from the band and ratio selection
  always_comb begin
    unique case ({bandSel_e'(bandSel), ratioSel})
      {BAND_HIGH, 1'b0}: newP = PRE_W'(P_HI_LO);
      {BAND_HIGH, 1'b1}: newP = PRE_W'(P_HI_HI);
      {BAND_LOW,  1'b0}: newP = PRE_W'(P_LO_LO);
      default:           newP = PRE_W'(P_LO_HI);
    endcase
  end

  // counts down from modulus-1 (P or P+1 cycles per tick) to zero
  always_ff @(posedge clk) begin
    if (strobe.load) begin
      curP   <= newP;
      preCnt <= loadWide ? newP : newP - PRE_W'(1);
    end else if (strobe.step) begin
      preCnt <= nextWide ? curP : curP - PRE_W'(1);
    end else if (strobe.count) begin
      preCnt <= preCnt - PRE_W'(1);
    end
  end

  assign preZero = (preCnt == '0);

endmodule

// File: rtl/swallow_divider_counters.sv
module swallow_divider_counters
  import swallow_divider_pkg::*;
#(
  parameter int SW_W     = 7,
  parameter int MAIN_W   = 11,
  parameter int MAIN_MIN = 3
) (
  input  logic              clk,
  input  divStrobe_t        strobe,
  input  logic [SW_W-1:0]   swallowVal,
  input  logic [MAIN_W-1:0] mainVal,
  output logic              loadWide,
  output logic              nextWide,
  output logic              mainLast,
  output logic              modCtl
);

  logic [SW_W-1:0]   swCnt;
  logic [SW_W-1:0]   swNext;
  logic [MAIN_W-1:0] mainCnt;
  logic [MAIN_W-1:0] mainEff;

  // main values below the minimum are raised to it
  assign mainEff  = (mainVal < MAIN_W'(MAIN_MIN)) ? MAIN_W'(MAIN_MIN) : mainVal;
  assign swNext   = (swCnt == '0) ? '0 : swCnt - SW_W'(1);
  assign loadWide = (swallowVal != '0);
  assign nextWide = (swNext != '0);

  // swCnt: P+1 ticks remaining, including the current one
  // mainCnt: ticks remaining in the period, including the current one
  always_ff @(posedge clk) begin
    if (strobe.load) begin
      swCnt   <= swallowVal;
      mainCnt <= mainEff;
    end else if (strobe.step) begin
      swCnt   <= swNext;
      mainCnt <= mainCnt - MAIN_W'(1);
    end
  end

  assign mainLast = (mainCnt == MAIN_W'(1));
  assign modCtl   = (swCnt != '0);

endmodule

// File: rtl/swallow_divider_datapath.sv
module swallow_divider_datapath
  import swallow_divider_pkg::*;
#(
  parameter int SW_W     = 7,
  parameter int MAIN_W   = 11,
  parameter int MAIN_MIN = 3,
  parameter int P_HI_LO  = 64,
  parameter int P_HI_HI  = 128,
  parameter int P_LO_LO  = 8,
  parameter int P_LO_HI  = 16
) (
  input  logic              clk,
  input  divStrobe_t        strobe,
  input  logic              bandSel,
  input  logic              ratioSel,
  input  logic [SW_W-1:0]   swallowVal,
  input  logic [MAIN_W-1:0] mainVal,
  output logic              preZero,
  output logic              mainLast,
  output logic              modCtl
);

  logic loadWide;
  logic nextWide;

  swallow_divider_prescaler #(
    .P_HI_LO(P_HI_LO), .P_HI_HI(P_HI_HI),
    .P_LO_LO(P_LO_LO), .P_LO_HI(P_LO_HI)
  ) u_prescaler (
    .clk      (clk),
    .strobe   (strobe),
    .bandSel  (bandSel),
    .ratioSel (ratioSel),
    .loadWide (loadWide),
    .nextWide (nextWide),
    .preZero  (preZero)
  );

  swallow_divider_counters #(
    .SW_W(SW_W), .MAIN_W(MAIN_W), .MAIN_MIN(MAIN_MIN)
  ) u_counters (
    .clk        (clk),
    .strobe     (strobe),
    .swallowVal (swallowVal),
    .mainVal    (mainVal),
    .loadWide   (loadWide),
    .nextWide   (nextWide),
    .mainLast   (mainLast),
    .modCtl     (modCtl)
  );

endmodule

// File: rtl/swallow_divider_ctrl.sv
module swallow_divider_ctrl
  import swallow_divider_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       preZero,
  input  logic       mainLast,
  output divStrobe_t strobe,
  output logic       divPulse
);

  logic endOfPeriod;

  assign endOfPeriod = preZero & mainLast;

  always_comb begin
    strobe.load  = rst | endOfPeriod;
    strobe.step  = ~rst & preZero & ~mainLast;
    strobe.count = ~rst & ~preZero;
  end

  always_ff @(posedge clk) begin
    if (rst) divPulse <= 1'b0;
    else     divPulse <= endOfPeriod;
  end

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swallow_divider_pkg::*;
#(
  parameter int SW_W     = 7,
  parameter int MAIN_W   = 11,
  parameter int MAIN_MIN = 3,
  parameter int P_HI_LO  = 64,
  parameter int P_HI_HI  = 128,
  parameter int P_LO_LO  = 8,
  parameter int P_LO_HI  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bandSel,
  input  logic              ratioSel,
  input  logic [SW_W-1:0]   swallowVal,
  input  logic [MAIN_W-1:0] mainVal,
  output logic              modCtl,
  output logic              divPulse
);

  divStrobe_t strobe;
  logic       preZero;
  logic       mainLast;

  swallow_divider_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .preZero  (preZero),
    .mainLast (mainLast),
    .strobe   (strobe),
    .divPulse (divPulse)
  );

  swallow_divider_datapath #(
    .SW_W(SW_W), .MAIN_W(MAIN_W), .MAIN_MIN(MAIN_MIN),
    .P_HI_LO(P_HI_LO), .P_HI_HI(P_HI_HI),
    .P_LO_LO(P_LO_LO), .P_LO_HI(P_LO_HI)
  ) u_datapath (
    .clk        (clk),
    .strobe     (strobe),
    .bandSel    (bandSel),
    .ratioSel   (ratioSel),
    .swallowVal (swallowVal),
    .mainVal    (mainVal),
    .preZero    (preZero),
    .mainLast   (mainLast),
    .modCtl     (modCtl)
  );

endmodule

// File: rtl/swallow_divider_checker.sv
module swallow_divider_checker #(
  parameter int MIN_RATIO = 24
) (
  input logic clk,
  input logic rst,
  input logic modCtl,
  input logic divPulse
);

  logic        havePrev;
  logic [31:0] gapCnt;

  // gapCnt counts input cycles since the last pulse, the pulse cycle included
  always_ff @(posedge clk) begin
    if (rst) begin
      havePrev <= 1'b0;
      gapCnt   <= '0;
    end else if (divPulse) begin
      havePrev <= 1'b1;
      gapCnt   <= 32'd1;
    end else begin
      gapCnt   <= gapCnt + 32'd1;
    end
  end

  assert_quiet_in_reset_R1: assert property (@(posedge clk) rst |=> !divPulse);

  assert_wide_starts_at_boundary_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(modCtl) |-> divPulse);

  assert_single_cycle_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    divPulse |=> !divPulse);

  assert_min_ratio_R9: assert property (@(posedge clk) disable iff (rst)
    (divPulse && havePrev) |-> (gapCnt >= 32'(MIN_RATIO)));

endmodule

bind swallow_divider swallow_divider_checker #(
  .MIN_RATIO(MAIN_MIN * P_LO_LO)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .modCtl   (modCtl),
  .divPulse (divPulse)
);

// File: tb/swallow_divider_bench.sv
module swallow_divider_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 40000;
  localparam int NVEC       = 8;

  typedef struct packed {
    logic        band;
    logic        rsel;
    logic [6:0]  a;
    logic [10:0] n;
  } vec_t;

  // band 1 = low (8/16), band 0 = high (64/128); rsel picks the larger modulus
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 7'd2,  11'd4},   // R2
    '{1'b1, 1'b0, 7'd7,  11'd9},   // R2
    '{1'b1, 1'b1, 7'd5,  11'd12},  // R3
    '{1'b1, 1'b1, 7'd0,  11'd6},   // R7
    '{1'b0, 1'b0, 7'd5,  11'd10},  // R4
    '{1'b0, 1'b1, 7'd7,  11'd20},  // R4
    '{1'b1, 1'b0, 7'd6,  11'd6},   // R8
    '{1'b1, 1'b1, 7'd1,  11'd3}    // R5
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bandSel = 1'b1;
  logic        ratioSel = 1'b0;
  logic [6:0]  swallowVal = '0;
  logic [10:0] mainVal = 11'd3;
  logic        modCtl;
  logic        divPulse;

  int nChecks = 0;
  int nFail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swallow_divider u_swallow_divider (
    .clk        (clk),
    .rst        (rst),
    .bandSel    (bandSel),
    .ratioSel   (ratioSel),
    .swallowVal (swallowVal),
    .mainVal    (mainVal),
    .modCtl     (modCtl),
    .divPulse   (divPulse)
  );

  function automatic int pOf(input logic band, input logic rsel);
    if (band) return rsel ? 16 : 8;
    return rsel ? 128 : 64;
  endfunction

  function automatic string tagOf(input int idx);
    case (idx)
      0, 1:    return "R2";
      2:       return "R3";
      3:       return "R7";
      4, 5:    return "R4";
      6:       return "R8";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input int actual, input int expected);
    nChecks++;
    if (actual != expected) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic setCfg(input logic band, input logic rsel, input int a, input int n);
    bandSel    = band;
    ratioSel   = rsel;
    swallowVal = 7'(a);
    mainVal    = 11'(n);
  endtask

  // leaves the bench at the falling edge where divPulse is seen high
  task automatic waitPulse();
    int k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!divPulse && k < LIMIT);
    if (!divPulse) begin
      nChecks++;
      nFail++;
      $display("FAIL timeout: actual no pulse expected pulse");
    end
  endtask

  // starts at a pulse sample; returns period length and modCtl-high count
  task automatic measure(output int len, output int wide);
    len  = 0;
    wide = 0;
    do begin
      if (modCtl) wide++;
      len++;
      @(negedge clk);
    end while (!divPulse && len < LIMIT);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    int len;
    int wide;
    int p;

    // R1: reset holds the pulse low, then first period has the full ratio
    setCfg(1'b1, 1'b0, 2, 4);
    repeat (4) @(negedge clk);
    check("R1 pulse low in reset", int'(divPulse), 0);
    check("R5 modCtl at period start", int'(modCtl), 1);
    rst = 1'b0;
    len = 0;
    do begin
      @(negedge clk);
      len++;
    end while (!divPulse && len < LIMIT);
    check("R1 first period after reset", len, 34);

    // table of configurations
    for (int i = 0; i < NVEC; i++) begin
      setCfg(VECS[i].band, VECS[i].rsel, int'(VECS[i].a), int'(VECS[i].n));
      p = pOf(VECS[i].band, VECS[i].rsel);
      waitPulse();
      measure(len, wide);
      check({tagOf(i), " ratio"}, len, p * int'(VECS[i].n) + int'(VECS[i].a));
      check({tagOf(i), " modCtl high cycles"}, wide, (p + 1) * int'(VECS[i].a));
      @(negedge clk);
      check("R6 pulse one cycle", int'(divPulse), 0);
    end

    // R9: main values below three behave as three
    for (int n = 0; n < 3; n++) begin
      setCfg(1'b1, 1'b0, 1, n);
      waitPulse();
      measure(len, wide);
      check("R9 clamped ratio", len, 25);
      check("R9 clamped modCtl", wide, 9);
    end

    // R10: change mid-period, current period unchanged, next period new
    setCfg(1'b1, 1'b0, 3, 5);
    waitPulse();
    measure(len, wide);
    check("R10 baseline ratio", len, 43);
    len = 0;
    do begin
      if (len == 5) setCfg(1'b1, 1'b1, 1, 4);
      len++;
      @(negedge clk);
    end while (!divPulse && len < LIMIT);
    check("R10 period kept old ratio", len, 43);
    measure(len, wide);
    check("R10 new ratio applied", len, 65);
    check("R10 new modCtl width", wide, 17);

    // R11: largest main value with largest swallow value
    setCfg(1'b1, 1'b0, 127, 2047);
    waitPulse();
    measure(len, wide);
    check("R11 max ratio", len, 8 * 2047 + 127);
    check("R11 max modCtl width", wide, 9 * 127);

    // R1: reset mid-period suppresses the pulse and restarts the count
    setCfg(1'b1, 1'b0, 0, 3);
    waitPulse();
    repeat (3) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 pulse low in second reset", int'(divPulse), 0);
    rst = 1'b0;
    len = 0;
    do begin
      @(negedge clk);
      len++;
    end while (!divPulse && len < LIMIT);
    check("R1 restart period", len, 24);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule